// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out a vector-length setup operation against a 64-bit vector state word. It chooses a maximum vector length (MVL) and an active vector length (VL) and writes both back into the state word. It also returns the chosen VL so that it can be written to a destination register. The pipeline passes in the current state word, a small immediate, two mode bits, the source operand value, the loop-count register value, and two flags that say whether the source and destination register specifiers are zero.

VL is picked from one of four places: the existing state, the source operand, the loop counter or the immediate. A register-sourced value saturates to seven bits. The chosen VL is then limited to MVL. Both saturation and limiting set a single overflow output, which a later stage can use to form a condition summary. A request to set MVL also loads the vertical-first mode bit and clears the persist bit.

The whole evaluation is combinational. It is captured on a valid strobe, and every result appears one clock later.

Top module: `vlcfg_unit`

## Requirements
- R1: With `set_max`=1, MVL is the low 7 bits of `imm_fld`+1, so an immediate of 127 gives MVL 0. With `set_max`=0, MVL is taken from bits [6:0] of `state_in`.
- R2: With `set_len`=0, the candidate VL is taken from bits [13:7] of `state_in`.
- R3: With `set_len`=1 and `src_is_zero`=0, the candidate VL is `src_value`. A value above 127 (unsigned) becomes 127 and sets `ovf`.
- R4: With `set_len`=1 and both `src_is_zero`=1 and `dst_is_zero`=1, the candidate VL is the low 7 bits of `imm_fld`+1.
- R5: With `set_len`=1, `src_is_zero`=1 and `dst_is_zero`=0, the candidate VL is `loop_count`, saturated to 127 with `ovf` set, in the same way as R3.
- R6: A candidate VL above MVL (unsigned) is replaced by MVL and sets `ovf`. `ovf` is 0 when neither this case nor saturation occurs.
- R7: `state_out` holds MVL in bits [6:0] and VL in bits [13:7]. Bits [61:14] are copied from `state_in`.
- R8: `dst_we` is a one-cycle pulse after a valid operation with `dst_is_zero`=0. `dst_data` carries VL zero-extended to 64 bits.
- R9: With `set_max`=1, bit 63 of `state_out` takes `vf_mode_in` and bit 62 is cleared. With `set_max`=0, bits 63 and 62 are copied from `state_in`.
- R10: Results appear on the clock after `op_valid`. Without `op_valid`, `state_out`, `dst_data` and `ovf` hold their values and `dst_we` is 0.
- R11: During synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Evaluate the operation this cycle |
| imm_fld | input | 7 | Immediate field (length minus one) |
| set_max | input | 1 | Load MVL from the immediate |
| set_len | input | 1 | Load VL from a new source |
| vf_mode_in | input | 1 | Vertical-first mode value for bit 63 |
| src_is_zero | input | 1 | Source register specifier is zero |
| dst_is_zero | input | 1 | Destination register specifier is zero |
| src_value | input | 64 | Source operand value |
| loop_count | input | 64 | Loop-count register value |
| state_in | input | 64 | Current vector state word |
| state_out | output | 64 | Updated vector state word |
| dst_we | output | 1 | Destination write enable (one-cycle pulse) |
| dst_data | output | 64 | Destination write data |
| ovf | output | 1 | Saturation or clamp occurred |

## Verification
Saturation of a register source and limiting to MVL can both occur in one operation. The bench provokes this with a source operand or loop count well above 127 while MVL is small, for example 300 against an MVL of 20. It also pairs an immediate of 127, which gives MVL 0, with a nonzero stored VL. The bench model applies both rules one after the other. It expects exactly one raised `ovf` and a VL equal to MVL. An RTL that drops either flag source, or that limits before saturating, shows a mismatch.

// File: rtl/vlcfg_pkg.sv
// Package: shared widths and state-word field positions for the vector
// length configuration unit. Assumes LEN_W-bit fields for MVL and VL.
package vlcfg_pkg;
    localparam int DATA_W      = 64;
    localparam int LEN_W       = 7;
    localparam int IMM_W       = 7;
    localparam int MVL_LSB     = 0;
    localparam int VL_LSB      = MVL_LSB + LEN_W;
    localparam int FIELD_TOP   = VL_LSB + LEN_W;
    localparam int PERSIST_BIT = DATA_W - 2;
    localparam int VFIRST_BIT  = DATA_W - 1;

    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        len_t mvl;
        len_t vl;
        logic ovf;
    } len_result_t;
endpackage

// File: rtl/vlcfg_sat.sv
// Module: unsigned saturation of a wide operand to OUT_W bits.
// Assumes IN_W > OUT_W. Flags when any bit above OUT_W is set.
module vlcfg_sat #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 7
) (
    input  logic [IN_W-1:0]  val_in,
    output logic [OUT_W-1:0] val_out,
    output logic             sat_hit
);
    localparam int HI_W = IN_W - OUT_W;

    logic [HI_W-1:0] upper;

    // Split the operand and choose the saturated or truncated value.
    always_comb begin
        upper   = val_in[IN_W-1:OUT_W];
        sat_hit = |upper;
        val_out = sat_hit ? {OUT_W{1'b1}} : val_in[OUT_W-1:0];
    end
endmodule

// File: rtl/vlcfg_len_pick.sv
// Module: picks the candidate VL from state, source operand, loop counter
// or immediate. Register sources saturate. Assumes the immediate length is
// already formed by the caller.
module vlcfg_len_pick
    import vlcfg_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic  set_len,
    input  logic  src_is_zero,
    input  logic  dst_is_zero,
    input  word_t src_value,
    input  word_t loop_count,
    input  len_t  imm_len,
    input  len_t  cur_vl,
    output len_t  vl_raw,
    output logic  sat_ovf
);
    word_t      opnd [NSRC];
    len_t       sat_val [NSRC];
    logic [NSRC-1:0] sat_flag;

    // Gather the register operands that need saturation (0: source, 1: loop).
    always_comb begin
        opnd[0] = src_value;
        opnd[1] = loop_count;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_sat
        vlcfg_sat #(.IN_W(DATA_W), .OUT_W(LEN_W)) u_sat (
            .val_in  (opnd[g]),
            .val_out (sat_val[g]),
            .sat_hit (sat_flag[g])
        );
    end

    // Priority choice of the VL source and its saturation flag.
    always_comb begin
        vl_raw  = cur_vl;
        sat_ovf = 1'b0;
        if (set_len) begin
            if (!src_is_zero) begin
                vl_raw  = sat_val[0];
                sat_ovf = sat_flag[0];
            end else if (dst_is_zero) begin
                vl_raw  = imm_len;
            end else begin
                vl_raw  = sat_val[1];
                sat_ovf = sat_flag[1];
            end
        end
    end
endmodule

// File: rtl/vlcfg_clamp.sv
// Module: limits the candidate VL to MVL and merges the overflow sources.
// Assumes unsigned LEN_W-bit lengths.
module vlcfg_clamp
    import vlcfg_pkg::*;
(
    input  len_t        mvl,
    input  len_t        vl_raw,
    input  logic        sat_ovf,
    output len_result_t res
);
    logic too_long;

    // Compare against MVL and form the final lengths and flag.
    always_comb begin
        too_long = vl_raw > mvl;
        res.mvl  = mvl;
        res.vl   = too_long ? mvl : vl_raw;
        res.ovf  = sat_ovf | too_long;
    end

    // R6: the limited VL never exceeds MVL.
    always_comb begin
        p_vl_le_mvl_r6: assert (res.vl <= res.mvl);
    end
endmodule

// File: rtl/vlcfg_unit.sv
// Module: top of the vector length configuration unit. It evaluates one
// set-length operation per valid strobe and registers the new state word,
// the destination write data and enable, and the overflow flag.
// Assumes the caller feeds the current state word each operation.
module vlcfg_unit
    import vlcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [IMM_W-1:0]  imm_fld,
    input  logic              set_max,
    input  logic              set_len,
    input  logic              vf_mode_in,
    input  logic              src_is_zero,
    input  logic              dst_is_zero,
    input  logic [DATA_W-1:0] src_value,
    input  logic [DATA_W-1:0] loop_count,
    input  logic [DATA_W-1:0] state_in,
    output logic [DATA_W-1:0] state_out,
    output logic              dst_we,
    output logic [DATA_W-1:0] dst_data,
    output logic              ovf
);
    logic [IMM_W:0] imm_p1;
    len_t           imm_len;
    len_t           mvl_sel;
    len_t           vl_raw;
    logic           sat_ovf;
    len_result_t    res;
    word_t          next_state;

    // Form the immediate length and choose MVL.
    always_comb begin
        imm_p1  = {1'b0, imm_fld} + {{IMM_W{1'b0}}, 1'b1};
        imm_len = imm_p1[LEN_W-1:0];
        mvl_sel = set_max ? imm_len : state_in[MVL_LSB +: LEN_W];
    end

    vlcfg_len_pick #(.NSRC(2)) u_pick (
        .set_len     (set_len),
        .src_is_zero (src_is_zero),
        .dst_is_zero (dst_is_zero),
        .src_value   (src_value),
        .loop_count  (loop_count),
        .imm_len     (imm_len),
        .cur_vl      (state_in[VL_LSB +: LEN_W]),
        .vl_raw      (vl_raw),
        .sat_ovf     (sat_ovf)
    );

    vlcfg_clamp u_clamp (
        .mvl    (mvl_sel),
        .vl_raw (vl_raw),
        .sat_ovf(sat_ovf),
        .res    (res)
    );

    // Merge the new fields and mode bits into the state word.
    always_comb begin
        next_state = state_in;
        next_state[MVL_LSB +: LEN_W] = res.mvl;
        next_state[VL_LSB  +: LEN_W] = res.vl;
        if (set_max) begin
            next_state[VFIRST_BIT]  = vf_mode_in;
            next_state[PERSIST_BIT] = 1'b0;
        end
    end

    // Register the results on a valid strobe; the write enable is a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_out <= '0;
            dst_we    <= 1'b0;
            dst_data  <= '0;
            ovf       <= 1'b0;
        end else begin
            dst_we <= op_valid & ~dst_is_zero;
            if (op_valid) begin
                state_out <= next_state;
                dst_data  <= {{(DATA_W-LEN_W){1'b0}}, res.vl};
                ovf       <= res.ovf;
            end
        end
    end

    // R10: outputs hold when no operation was strobed.
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> ($stable(state_out) && $stable(ovf) && !dst_we));

    // R8: a write pulse only follows a valid op with a nonzero destination.
    p_we_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> ($past(op_valid) && !$past(dst_is_zero)));

    // R9: a set-MVL operation leaves the persist bit clear.
    p_persist_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid) && $past(set_max)) |-> !state_out[PERSIST_BIT]);

    // R1: without set-MVL the stored MVL field is carried over.
    p_mvl_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid) && !$past(set_max)) |->
        (state_out[MVL_LSB +: LEN_W] == $past(state_in[MVL_LSB +: LEN_W])));

    // R7: bits outside the length fields and mode bits pass through.
    p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid) |->
        (state_out[PERSIST_BIT-1:FIELD_TOP] == $past(state_in[PERSIST_BIT-1:FIELD_TOP])));
endmodule

// File: tb/test_vlcfg_unit.sv
module test_vlcfg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [6:0]  imm_fld = '0;
    logic        set_max = 1'b0, set_len = 1'b0, vf_mode_in = 1'b0;
    logic        src_is_zero = 1'b1, dst_is_zero = 1'b1;
    logic [63:0] src_value = '0, loop_count = '0, state_in = '0;
    logic [63:0] state_out, dst_data;
    logic        dst_we, ovf;

    int checks = 0;
    int errors = 0;

    logic [63:0] exp_state = '0, exp_data = '0;
    logic        exp_we = 1'b0, exp_ovf = 1'b0;

    always #2 clk = ~clk;

    vlcfg_unit i_vlcfg_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .imm_fld(imm_fld),
        .set_max(set_max), .set_len(set_len), .vf_mode_in(vf_mode_in),
        .src_is_zero(src_is_zero), .dst_is_zero(dst_is_zero),
        .src_value(src_value), .loop_count(loop_count), .state_in(state_in),
        .state_out(state_out), .dst_we(dst_we), .dst_data(dst_data), .ovf(ovf)
    );

    task automatic check64(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check64(tag, "state_out", state_out, exp_state);
        check64(tag, "dst_we", {63'd0, dst_we}, {63'd0, exp_we});
        check64(tag, "dst_data", dst_data, exp_data);
        check64(tag, "ovf", {63'd0, ovf}, {63'd0, exp_ovf});
    endtask

    // Behavioural reference computed with plain integers.
    task automatic predict();
        longint unsigned mx, len, imm1;
        bit o;
        logic [63:0] ns;
        o    = 0;
        imm1 = (longint'(imm_fld) + 1) % 128;
        mx   = set_max ? imm1 : (state_in % 128);
        if (!set_len)          len = (state_in / 128) % 128;
        else if (!src_is_zero) begin
            if (src_value > 127) begin len = 127; o = 1; end else len = src_value;
        end else if (dst_is_zero) len = imm1;
        else begin
            if (loop_count > 127) begin len = 127; o = 1; end else len = loop_count;
        end
        if (len > mx) begin len = mx; o = 1; end
        ns = state_in;
        ns[13:0] = 14'(len * 128 + mx);
        if (set_max) begin ns[63] = vf_mode_in; ns[62] = 1'b0; end
        exp_state = ns;
        exp_data  = 64'(len);
        exp_ovf   = o;
        exp_we    = !dst_is_zero;
    endtask

    task automatic run_op(input string tag, input bit smax, input bit slen,
                          input bit vf, input logic [6:0] imm, input bit sz,
                          input bit dz, input logic [63:0] sv,
                          input logic [63:0] lc, input logic [63:0] st);
        @(negedge clk);
        set_max = smax; set_len = slen; vf_mode_in = vf; imm_fld = imm;
        src_is_zero = sz; dst_is_zero = dz; src_value = sv;
        loop_count = lc; state_in = st; op_valid = 1'b1;
        predict();
        @(negedge clk);
        op_valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        state_in = ~state_in;
        src_is_zero = 1'b0;
        dst_is_zero = 1'b0;
        exp_we = 1'b0;
        compare_all(tag);
    endtask

    function automatic logic [63:0] mkst(input int mvl, input int vl);
        return (64'h0123_4567_89AB_C000 & ~64'h3FFF) | 64'(vl * 128 + mvl);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R11");
        rst_n = 1'b1;

        // R1: MVL from immediate, VL kept from state
        run_op("R1", 1, 0, 0, 7'd9, 1, 1, 0, 0, mkst(3, 5));
        // R1: immediate 127 wraps MVL to 0, VL clamps (R6)
        run_op("R1", 1, 0, 1, 7'd127, 1, 1, 0, 0, mkst(3, 5));
        // R2: keep both fields
        run_op("R2", 0, 0, 0, 7'd0, 1, 1, 0, 0, mkst(50, 30));
        // R3: source operand paths
        run_op("R3", 0, 1, 0, 7'd0, 0, 0, 64'd40, 64'd9, mkst(100, 1));
        run_op("R3", 0, 1, 0, 7'd0, 0, 0, 64'd127, 64'd9, mkst(127, 1));
        run_op("R3", 0, 1, 0, 7'd0, 0, 0, 64'd128, 64'd9, mkst(127, 1));
        run_op("R3", 0, 1, 0, 7'd0, 0, 1, 64'hFFFF_0000_0000_0001, 0, mkst(127, 1));
        // R4: immediate length
        run_op("R4", 0, 1, 0, 7'd19, 1, 1, 64'd5, 64'd7, mkst(100, 2));
        // R5: loop counter
        run_op("R5", 0, 1, 0, 7'd3, 1, 0, 64'd5, 64'd1000, mkst(127, 2));
        run_op("R5", 0, 1, 0, 7'd3, 1, 0, 64'd5, 64'd64, mkst(127, 2));
        // R6: saturation and clamp in the same operation
        run_op("R6", 0, 1, 0, 7'd0, 0, 0, 64'd300, 64'd0, mkst(20, 2));
        run_op("R6", 0, 1, 0, 7'd0, 1, 0, 64'd0, 64'd5000, mkst(20, 2));
        // R9: mode bits set and passed through
        run_op("R9", 1, 0, 1, 7'd10, 1, 0, 0, 0, mkst(0, 4) | 64'h4000_0000_0000_0000);
        run_op("R9", 0, 0, 0, 7'd10, 1, 0, 0, 0, mkst(9, 4) | 64'hC000_0000_0000_0000);
        // R10 / R8: hold with no strobe, no write pulse
        idle("R10");
        idle("R8");

        // R7: mixed random operations
        for (int k = 0; k < 300; k++) begin
            logic [63:0] sv, lc;
            sv = ($urandom % 3 == 0) ? {32'($urandom), 32'($urandom)} : 64'($urandom % 200);
            lc = ($urandom % 3 == 0) ? {32'($urandom), 32'($urandom)} : 64'($urandom % 200);
            run_op("R7", 1'($urandom), 1'($urandom), 1'($urandom), 7'($urandom),
                   1'($urandom), 1'($urandom), sv, lc, {32'($urandom), 32'($urandom)});
            if (k % 7 == 0) idle("R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule